// File: doc/BRIEF.md
# Parallel LCD Register Bus Master

This block drives an 18-pin parallel bus of the 8080 style that connects to a display controller. It carries out register writes and register reads. A client gives it one operation at a time: write a register index, write a register value, or read a register. Each operation comes with a 16-bit payload. The block then produces chip select, register select, write strobe and a read/enable strobe. It also drives the data pins, and on a read it releases them and samples them.

A 16-bit value does not fill the bus in order. The low byte travels on pins 8..1 and the high byte on pins 17..10. Pins 0 and 9 carry zero when driven and are ignored when read.

A register write takes two operations: an index cycle followed by a data cycle. A read runs a fixed thirteen-step strobe sequence. The write strobe sends the index, the bus is then handed over to the display, and the enable strobe is pulsed to return the value. The timing ports set the setup, hold and step lengths in clock cycles. A watchdog aborts an operation that stays busy for too long.

Top module: `lcd_regbus_master`

## Requirements
- R1: A driven 16-bit value appears with bits 7:0 on bus pins 8:1 and bits 15:8 on pins 17:10, while pins 0 and 9 are zero. This holds for write operations and for the index phase of a read.
- R2: Read data is unpacked with the same lane mapping: result bits 7:0 come from pins 8:1 and bits 15:8 from pins 17:10. Whatever is on pins 0 and 9 has no effect on the result.
- R3: Operation codes are 0 = index (command) cycle with register select low, 1 = data cycle with register select high, and 2 = register read. Code 3 is never accepted and starts no bus activity.
- R4: A write cycle has three phases, and chip select is low in all of them.
  - First, the value is driven with the write strobe high for the setup count.
  - Next, the write strobe is low for the step count.
  - Last, the strobe is high again with the value held for the hold count.
  - Index cycles use the command setup and hold counts. Data cycles use the data setup and hold counts.
  - A count of zero acts as one, so busy lasts setup+step+hold cycles.
- R5: A read runs these steps in order:
  - park with all strobes high and the bus driven to zero;
  - register select low, then chip select low, then write strobe low;
  - drive the packed index, then release the write strobe;
  - tristate the bus;
  - enable low, then register select high;
  - enable high, then enable low, then enable high;
  - chip select high.
- R6: Each read step lasts the step count (zero acts as one), so a read keeps busy for 13 steps. The bus is tristated for a full step before the enable strobe first falls, and it stays tristated until the read ends.
- R7: The read result is captured during the last cycle of the second enable-low step. It stays unchanged until the next completed read.
- R8: A request is accepted only while the engine is idle. A request held or presented while busy has no effect on the running operation and does not start another one after it.
- R9: done pulses high for exactly one cycle, in the first idle cycle after an operation completes normally.
- R10: If busy lasts the timeout count of cycles (a timeout of zero disables this), the engine returns to idle with the strobes inactive. err is set, done does not pulse and the read result is not updated. err clears when the next request is accepted.
- R11: In reset the strobes are inactive (chip select, register select, write strobe and enable all high), the bus is not driven, and busy, done, err and the read result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (0 index, 1 data, 2 read) |
| req_payload | input | 16 | Value to write, or register index to read |
| cfg_cmd_setup | input | 4 | Setup cycles for index cycles |
| cfg_cmd_hold | input | 4 | Hold cycles for index cycles |
| cfg_dat_setup | input | 4 | Setup cycles for data cycles |
| cfg_dat_hold | input | 4 | Hold cycles for data cycles |
| cfg_step | input | 4 | Cycles per strobe step |
| cfg_timeout | input | 16 | Busy limit in cycles, 0 disables |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation aborted by timeout |
| rd_data | output | 16 | Result of last completed read |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select, low = command |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read/enable strobe, active low |
| lcd_oe | output | 1 | Bus output enable for the pad |
| lcd_dout | output | 18 | Bus value driven when lcd_oe is high |
| lcd_din | input | 18 | Bus value sampled from the pins |

## Verification
The bench builds the block with its default parameters: 16-bit values on an 18-pin bus, 4-bit timing counts and a 16-bit timeout.

First it runs the default timings (2/2 command, 1/2 data) with two cycles per step. This shows that each phase has its own length, and it lets the recorded strobe pattern tell every step of the read apart.

It then sets the step count and one setup count to zero, which exercises the clamp to a single cycle. Finally it programs a timeout of seven cycles, shorter than any read, so that the abort path is hit part-way through the index phase.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [1:0] {
    OP_INDEX = 2'd0,
    OP_DATA  = 2'd1,
    OP_READ  = 2'd2
  } lcd_op_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_STROBE,
    ST_W_HOLD,
    ST_R_PARK,
    ST_R_RS,
    ST_R_CS,
    ST_R_WR,
    ST_R_IDX,
    ST_R_WREL,
    ST_R_TRI,
    ST_R_EN1,
    ST_R_RSHI,
    ST_R_ENHI,
    ST_R_EN2,
    ST_R_ENREL,
    ST_R_CSREL
  } lcd_state_e;

  // low byte lane starts at pin 1; the high lane follows one spare pin later
  localparam int LO_BASE = 1;

endpackage

// File: rtl/lcd_lane_map.sv
module lcd_lane_map
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUS_W  = DATA_W + 2
) (
  input  logic [DATA_W-1:0] word_in,
  output logic [BUS_W-1:0]  bus_out,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [DATA_W-1:0] word_out
);
  localparam int HALF  = DATA_W / 2;
  localparam int GAP   = LO_BASE + HALF;
  localparam int HI_BASE = GAP + 1;

  logic unused_spare_pins;

  generate
    for (genvar i = 0; i < HALF; i++) begin : g_lane
      assign bus_out[LO_BASE+i]   = word_in[i];
      assign bus_out[HI_BASE+i]   = word_in[HALF+i];
      assign word_out[i]          = bus_in[LO_BASE+i];
      assign word_out[HALF+i]     = bus_in[HI_BASE+i];
    end
  endgenerate

  assign bus_out[0]   = 1'b0;
  assign bus_out[GAP] = 1'b0;
  assign unused_spare_pins = bus_in[0] ^ bus_in[GAP];

endmodule

// File: rtl/lcd_step_timer.sv
module lcd_step_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = (len == '0) ? '0 : len - 1'b1;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/lcd_busy_watchdog.sv
module lcd_busy_watchdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [TMO_W-1:0] limit,
  output logic             trip
);
  logic [TMO_W-1:0] cnt_q, cnt_d;

  assign trip = active && (limit != '0) && (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_d = '0;
    if (active) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lcd_regbus_master.sv
module lcd_regbus_master
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUS_W  = DATA_W + 2,
  parameter int CNT_W  = 4,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_payload,
  input  logic [CNT_W-1:0]  cfg_cmd_setup,
  input  logic [CNT_W-1:0]  cfg_cmd_hold,
  input  logic [CNT_W-1:0]  cfg_dat_setup,
  input  logic [CNT_W-1:0]  cfg_dat_hold,
  input  logic [CNT_W-1:0]  cfg_step,
  input  logic [TMO_W-1:0]  cfg_timeout,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              lcd_cs_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic              lcd_oe,
  output logic [BUS_W-1:0]  lcd_dout,
  input  logic [BUS_W-1:0]  lcd_din
);
  lcd_state_e        state_q, state_d;
  logic              is_data_q, data_sel;
  logic [DATA_W-1:0] payload_q;
  logic [DATA_W-1:0] rd_data_q, din_word;
  logic [BUS_W-1:0]  packed_bus;
  logic              done_q, done_d, err_q, err_d;
  logic              accept, capture, step_load, step_expire, trip;
  logic [CNT_W-1:0]  len_d;

  assign accept = (state_q == ST_IDLE) && req_valid &&
                  (req_op == OP_INDEX || req_op == OP_DATA || req_op == OP_READ);
  assign busy   = (state_q != ST_IDLE);

  lcd_lane_map #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_lanes (
    .word_in (payload_q),
    .bus_out (packed_bus),
    .bus_in  (lcd_din),
    .word_out(din_word)
  );

  lcd_step_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (step_load),
    .len   (len_d),
    .expire(step_expire)
  );

  lcd_busy_watchdog #(.TMO_W(TMO_W)) i_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .active(busy),
    .limit (cfg_timeout),
    .trip  (trip)
  );

  // sequencer next state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = err_q;
    capture = 1'b0;
    if (state_q == ST_IDLE) begin
      if (accept) begin
        err_d   = 1'b0;
        state_d = (req_op == OP_READ) ? ST_R_PARK : ST_W_SETUP;
      end
    end else if (trip) begin
      state_d = ST_IDLE;
      err_d   = 1'b1;
    end else if (step_expire) begin
      unique case (state_q)
        ST_W_SETUP:  state_d = ST_W_STROBE;
        ST_W_STROBE: state_d = ST_W_HOLD;
        ST_W_HOLD:   begin state_d = ST_IDLE; done_d = 1'b1; end
        ST_R_PARK:   state_d = ST_R_RS;
        ST_R_RS:     state_d = ST_R_CS;
        ST_R_CS:     state_d = ST_R_WR;
        ST_R_WR:     state_d = ST_R_IDX;
        ST_R_IDX:    state_d = ST_R_WREL;
        ST_R_WREL:   state_d = ST_R_TRI;
        ST_R_TRI:    state_d = ST_R_EN1;
        ST_R_EN1:    state_d = ST_R_RSHI;
        ST_R_RSHI:   state_d = ST_R_ENHI;
        ST_R_ENHI:   state_d = ST_R_EN2;
        ST_R_EN2:    begin state_d = ST_R_ENREL; capture = 1'b1; end
        ST_R_ENREL:  state_d = ST_R_CSREL;
        ST_R_CSREL:  begin state_d = ST_IDLE; done_d = 1'b1; end
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  // phase length for the state about to be entered
  assign data_sel  = accept ? (req_op == OP_DATA) : is_data_q;
  assign step_load = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_W_SETUP: len_d = data_sel ? cfg_dat_setup : cfg_cmd_setup;
      ST_W_HOLD:  len_d = data_sel ? cfg_dat_hold  : cfg_cmd_hold;
      default:    len_d = cfg_step;
    endcase
  end

  // pin decode from registered state
  always_comb begin
    lcd_cs_n = 1'b1;
    lcd_rs   = 1'b1;
    lcd_wr_n = 1'b1;
    lcd_rd_n = 1'b1;
    lcd_oe   = 1'b0;
    lcd_dout = '0;
    unique case (state_q)
      ST_W_SETUP, ST_W_HOLD: begin
        lcd_cs_n = 1'b0; lcd_rs = is_data_q; lcd_oe = 1'b1; lcd_dout = packed_bus;
      end
      ST_W_STROBE: begin
        lcd_cs_n = 1'b0; lcd_rs = is_data_q; lcd_wr_n = 1'b0;
        lcd_oe = 1'b1; lcd_dout = packed_bus;
      end
      ST_R_PARK:  lcd_oe = 1'b1;
      ST_R_RS:    begin lcd_rs = 1'b0; lcd_oe = 1'b1; end
      ST_R_CS:    begin lcd_rs = 1'b0; lcd_cs_n = 1'b0; lcd_oe = 1'b1; end
      ST_R_WR:    begin lcd_rs = 1'b0; lcd_cs_n = 1'b0; lcd_wr_n = 1'b0; lcd_oe = 1'b1; end
      ST_R_IDX:   begin
        lcd_rs = 1'b0; lcd_cs_n = 1'b0; lcd_wr_n = 1'b0; lcd_oe = 1'b1; lcd_dout = packed_bus;
      end
      ST_R_WREL:  begin lcd_rs = 1'b0; lcd_cs_n = 1'b0; lcd_oe = 1'b1; lcd_dout = packed_bus; end
      ST_R_TRI:   begin lcd_rs = 1'b0; lcd_cs_n = 1'b0; end
      ST_R_EN1:   begin lcd_rs = 1'b0; lcd_cs_n = 1'b0; lcd_rd_n = 1'b0; end
      ST_R_RSHI:  begin lcd_cs_n = 1'b0; lcd_rd_n = 1'b0; end
      ST_R_ENHI:  lcd_cs_n = 1'b0;
      ST_R_EN2:   begin lcd_cs_n = 1'b0; lcd_rd_n = 1'b0; end
      ST_R_ENREL: lcd_cs_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_data_q <= 1'b0;
      payload_q <= '0;
    end else if (accept) begin
      is_data_q <= (req_op == OP_DATA);
      payload_q <= req_payload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_q <= '0;
    else if (capture) rd_data_q <= din_word;
  end

  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rd_data_q;

endmodule

// File: rtl/lcd_regbus_checker.sv
module lcd_regbus_checker #(
  parameter int DATA_W = 16,
  parameter int BUS_W  = DATA_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] rd_data,
  input logic              lcd_cs_n,
  input logic              lcd_wr_n,
  input logic              lcd_rd_n,
  input logic              lcd_oe,
  input logic [BUS_W-1:0]  lcd_dout
);
  localparam int GAP = 1 + DATA_W / 2;

  p_spare_pins_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_oe |-> (lcd_dout[0] == 1'b0 && lcd_dout[GAP] == 1'b0));

  p_wr_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);

  p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_wr_n && !lcd_rd_n));

  p_no_drive_on_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> !lcd_oe);

  p_rdata_held_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rd_data));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && !done));

  p_idle_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_oe));

endmodule

bind lcd_regbus_master lcd_regbus_checker #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .rd_data (rd_data),
  .lcd_cs_n(lcd_cs_n),
  .lcd_wr_n(lcd_wr_n),
  .lcd_rd_n(lcd_rd_n),
  .lcd_oe  (lcd_oe),
  .lcd_dout(lcd_dout)
);

// File: tb/test_lcd_regbus_master.sv
`timescale 1ns/1ps
module test_lcd_regbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_payload = 16'h0;
  logic [3:0]  cfg_cmd_setup = 4'd2, cfg_cmd_hold = 4'd2;
  logic [3:0]  cfg_dat_setup = 4'd1, cfg_dat_hold = 4'd2;
  logic [3:0]  cfg_step = 4'd2;
  logic [15:0] cfg_timeout = 16'd0;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_oe;
  logic [17:0] lcd_dout;
  logic [17:0] lcd_din = 18'h0;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  lcd_regbus_master i_lcd_regbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_payload(req_payload), .cfg_cmd_setup(cfg_cmd_setup),
    .cfg_cmd_hold(cfg_cmd_hold), .cfg_dat_setup(cfg_dat_setup),
    .cfg_dat_hold(cfg_dat_hold), .cfg_step(cfg_step), .cfg_timeout(cfg_timeout),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_oe(lcd_oe), .lcd_dout(lcd_dout), .lcd_din(lcd_din)
  );

  // monitor: pin pattern per busy cycle, compressed on change
  logic [5:0]  tup [32];
  int          ntup, busy_cyc, done_cyc;
  logic [17:0] wr_val;
  logic        wr_rs, prev_wr = 1'b1;

  always @(negedge clk) begin
    logic [5:0] cur;
    cur = {lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_oe, |lcd_dout};
    if (busy) begin
      if (ntup == 0 || tup[ntup-1] != cur) begin
        if (ntup < 32) tup[ntup] = cur;
        ntup++;
      end
      busy_cyc++;
    end
    if (done) done_cyc++;
    if (!prev_wr && lcd_wr_n) begin
      wr_val = lcd_dout;
      wr_rs  = lcd_rs;
    end
    prev_wr = lcd_wr_n;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] tb_pack(input logic [15:0] w);
    return {w[15:8], 1'b0, w[7:0], 1'b0};
  endfunction

  function automatic logic [15:0] tb_unpack(input logic [17:0] b);
    return {b[17:10], b[8:1]};
  endfunction

  function automatic int cl(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // expected compressed pin pattern {cs,rs,wr,en,oe,nz}
  function automatic logic [5:0] exp_tup(input logic [1:0] op, input int i, input bit nz);
    if (op != 2'd2) begin
      logic rs;
      rs = (op == 2'd1);
      case (i)
        1:       return {1'b0, rs, 1'b0, 1'b1, 1'b1, nz};
        default: return {1'b0, rs, 1'b1, 1'b1, 1'b1, nz};
      endcase
    end
    case (i)
      0:  return 6'b111110;
      1:  return 6'b101110;
      2:  return 6'b001110;
      3:  return 6'b000110;
      4:  return {5'b00011, nz};
      5:  return {5'b00111, nz};
      6:  return 6'b001100;
      7:  return 6'b001000;
      8:  return 6'b011000;
      9:  return 6'b011100;
      10: return 6'b011000;
      11: return 6'b011100;
      default: return 6'b111100;
    endcase
  endfunction

  task automatic issue(input logic [1:0] op, input logic [15:0] pl);
    @(negedge clk); #1;
    ntup = 0; busy_cyc = 0; done_cyc = 0; wr_val = '0; wr_rs = 1'b0;
    req_valid = 1'b1; req_op = op; req_payload = pl;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000; n++) begin
      if (!busy) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
  endtask

  task automatic run_and_check(input logic [1:0] op, input logic [15:0] pl, input logic [17:0] din);
    int exp_len, exp_n;
    bit match;
    lcd_din = din;
    issue(op, pl);
    wait_idle();
    if (op == 2'd2) begin
      exp_len = 13 * cl(cfg_step);
      exp_n = 13;
    end else begin
      exp_len = (op == 2'd1) ? cl(cfg_dat_setup) + cl(cfg_step) + cl(cfg_dat_hold)
                             : cl(cfg_cmd_setup) + cl(cfg_step) + cl(cfg_cmd_hold);
      exp_n = 3;
    end
    chk(busy_cyc == exp_len, (op == 2'd2) ? "R6 read length" : "R4 write length", busy_cyc, exp_len);
    match = (ntup == exp_n);
    for (int i = 0; i < exp_n && i < 32; i++)
      if (tup[i] != exp_tup(op, i, pl != 0)) match = 1'b0;
    chk(match, (op == 2'd2) ? "R5 read pin sequence" : "R4 write pin sequence", ntup, exp_n);
    chk(done_cyc == 1, "R9 done pulse width", done_cyc, 1);
    chk(wr_val == tb_pack(pl), "R1 packed value at strobe release", wr_val, tb_pack(pl));
    if (op != 2'd2)
      chk(wr_rs == (op == 2'd1), "R3 register select level", wr_rs, (op == 2'd1));
    else
      chk(rd_data == tb_unpack(din), "R2 R7 read result", rd_data, tb_unpack(din));
  endtask

  // {op, payload, din}
  localparam logic [35:0] VEC [7] = '{
    {2'd0, 16'h00E5, 18'h00000},
    {2'd1, 16'h78F0, 18'h00000},
    {2'd2, 16'h0012, 18'h3FFFF},
    {2'd2, 16'h0101, 18'h00201},
    {2'd1, 16'h0000, 18'h00000},
    {2'd2, 16'h00EF, 18'h2A554},
    {2'd0, 16'hFFFF, 18'h00000}
  };

  initial begin
    logic [15:0] held;
    #1;
    // R11 reset state
    chk({lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n} == 4'hF, "R11 strobes inactive in reset",
        {lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n}, 4'hF);
    chk({lcd_oe, busy, done, err} == 4'h0 && rd_data == 16'h0, "R11 idle outputs in reset",
        {lcd_oe, busy, done, err, rd_data}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 7; v++)
      run_and_check(VEC[v][35:34], VEC[v][33:18], VEC[v][17:0]);

    // R7 result held across writes and changing pins
    held = rd_data;
    lcd_din = 18'h155AA;
    run_and_check(2'd1, 16'h1234, 18'h155AA);
    chk(rd_data == held, "R7 read result held", rd_data, held);

    // R4 R6 clamp of zero counts
    cfg_step = 4'd0; cfg_cmd_setup = 4'd0;
    run_and_check(2'd0, 16'h0022, 18'h0);
    run_and_check(2'd2, 16'h0300, 18'h0F0F3);
    cfg_step = 4'd2; cfg_cmd_setup = 4'd2;

    // R3 code 3 not accepted
    issue(2'd3, 16'hAAAA);
    repeat (5) @(negedge clk);
    #1;
    chk(busy_cyc == 0 && !busy, "R3 code 3 ignored", busy_cyc, 0);

    // R8 request while busy ignored
    issue(2'd1, 16'h0F0F);
    req_valid = 1'b1; req_op = 2'd0; req_payload = 16'hFFFF;
    repeat (3) @(negedge clk);
    #1 req_valid = 1'b0;
    wait_idle();
    chk(wr_val == tb_pack(16'h0F0F), "R8 running value unchanged", wr_val, tb_pack(16'h0F0F));
    busy_cyc = 0;
    repeat (6) @(negedge clk);
    #1;
    chk(busy_cyc == 0, "R8 no queued operation", busy_cyc, 0);

    // R10 timeout abort
    held = rd_data;
    cfg_timeout = 16'd7;
    lcd_din = 18'h3FFFF;
    issue(2'd2, 16'h0055);
    wait_idle();
    chk(busy_cyc == 7, "R10 busy length at abort", busy_cyc, 7);
    chk(err == 1'b1 && done_cyc == 0, "R10 err set without done", {err, done_cyc[7:0]}, 9'h100);
    chk(lcd_cs_n && !lcd_oe && lcd_wr_n, "R10 strobes released", {lcd_cs_n, lcd_oe, lcd_wr_n}, 3'b101);
    chk(rd_data == held, "R10 read result untouched", rd_data, held);
    cfg_timeout = 16'd0;
    issue(2'd0, 16'h0007);
    chk(err == 1'b0, "R10 err cleared on accept", err, 0);
    wait_idle();

    finish_run();
  end
endmodule